// File: doc/BRIEF.md
# Keyed-Refresh Watchdog Timer

This block is a watchdog counter that sits on a simple synchronous register bus and drives a reset request when software stops servicing it. Software restarts the count by writing a pair of 16-bit key words, one after the other, to the counter register. A second pair of key words opens a short span of bus cycles during which the configuration registers accept writes. Outside that span all configuration writes are dropped.

The counter advances on one of four tick sources: every bus clock, or one-cycle pulses from a low-power 1 kHz tick, a 32 kHz tick or an external tick. The tick pulses are assumed to be already synchronous to the bus clock. When the live count equals the terminal count while counting is enabled, the block sets a sticky timeout flag, clears the count and holds the reset output high for a fixed number of bus clocks. An optional refresh window makes an early refresh itself a fault. Software can also freeze the configuration until the next reset.

Bus map (byte addresses): a control byte at 0, a status/clock byte at 1, the counter/command word at 4, the terminal-count word at 8 and the window word at 12. A read of address 0 returns the status byte in bits 15:8 and the control byte in bits 7:0.

Top module: `kwdt_top`

## Requirements
- R1: After reset the control byte reads 0x20 (update-allow set, enable clear), the status byte reads 0x00, the count reads 0, the terminal count reads 0x1500, the window reads 0 and the reset output is low.
- R2: A word write of 0xA602 to address 4, followed on the very next write by a word write of 0xB480 to address 4, clears the count on the edge of the second write. Only bits 15:0 of a key word are compared.
- R3: The refresh sequence is cancelled, and the count is not cleared, when the second write carries a different value, when any other bus write comes between the two key words, or when 0xB480 arrives without a preceding 0xA602. No write to address 4 other than a completed refresh changes the count.
- R4: Writes to the control byte (bit 7 enable, bit 5 update-allow), the clock-select field (status bits 1:0), the terminal count and the window are ignored unless the unlock pair 0xC520 then 0xD928 has been written back-to-back to address 4.
- R5: After the unlock pair, configuration writes are accepted on the next 128 bus-clock edges. A write on the 129th edge is ignored.
- R6: An accepted control write with bit 7 set and bit 5 clear freezes the configuration until reset. It closes any open unlock span, and later unlock pairs open none.
- R7: Status bit 6 is the timeout flag. Writing 1 to it clears it, and writing 0 leaves it unchanged. This works whether or not the configuration is unlocked.
- R8: Clock select 0 advances the count on every bus clock. Selects 1, 2 and 3 advance it only on pulses of the 1 kHz, 32 kHz and external tick inputs. The count holds while counting is disabled.
- R9: When the count equals the terminal count while enabled, the next edge sets the flag, clears the count and raises the reset output for exactly 16 bus clocks.
- R10: With a nonzero window, a completed refresh that arrives while the count is below the window value is rejected. The count is not cleared, the flag is not set, and the reset output rises on the same edge for 16 bus clocks. A refresh at or above the window value is accepted normally.
- R11: A read of address 4 returns the live count. It increases by one per selected tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_lp_i | input | 1 | 1 kHz tick pulse, one bus clock wide |
| tick_32k_i | input | 1 | 32 kHz tick pulse, one bus clock wide |
| tick_ext_i | input | 1 | External tick pulse, one bus clock wide |
| bus_addr_i | input | 4 | Byte address of the access |
| bus_wdata_i | input | 32 | Write data (bytes use bits 7:0) |
| bus_wr_byte_i | input | 1 | Byte write strobe |
| bus_wr_word_i | input | 1 | Word write strobe |
| bus_rdata_o | output | 32 | Read data, combinational from the address |
| wdog_rst_o | output | 1 | Reset request output |

## Verification
Every write takes effect on the clock edge on which its strobe is sampled. Read data follows the address in the same cycle, so the bench drives on falling edges and reads just after them. A completed refresh shows a zero count at the next falling edge. A timeout is detected one edge after the count reaches the terminal count, so with the bus-clock tick the reset output rises N+1 edges after the enabling write. The bench waits that exact number of falling edges and checks the output there. It then counts the 16 high samples of the pulse and the low sample that follows them. The unlock span is probed by placing writes on the 128th and 129th edges after the second unlock word.

// File: rtl/kwdt_pkg.sv
// Shared constants and types for the keyed-refresh watchdog.
// Assumes byte addressing on a 4-bit address and 16-bit key words.
package kwdt_pkg;

    localparam logic [15:0] KEY_REFRESH_A = 16'hA602;
    localparam logic [15:0] KEY_REFRESH_B = 16'hB480;
    localparam logic [15:0] KEY_UNLOCK_A  = 16'hC520;
    localparam logic [15:0] KEY_UNLOCK_B  = 16'hD928;

    localparam logic [3:0] ADR_CTRL  = 4'd0;
    localparam logic [3:0] ADR_STAT  = 4'd1;
    localparam logic [3:0] ADR_COUNT = 4'd4;
    localparam logic [3:0] ADR_TERM  = 4'd8;
    localparam logic [3:0] ADR_WIN   = 4'd12;

    localparam int CTRL_RUN_BIT   = 7;
    localparam int CTRL_ALLOW_BIT = 5;
    localparam int STAT_FLAG_BIT  = 6;

    typedef enum logic [1:0] {
        KS_IDLE,
        KS_HAVE_REFRESH,
        KS_HAVE_UNLOCK
    } key_state_e;

    typedef enum logic [1:0] {
        TICK_BUS  = 2'd0,
        TICK_SLOW = 2'd1,
        TICK_32K  = 2'd2,
        TICK_EXT  = 2'd3
    } tick_sel_e;

endpackage

// File: rtl/kwdt_keyseq.sv
// Key sequence detector: watches every bus write and flags a completed
// refresh pair or unlock pair on the edge of the second word.
// Assumes at most one write strobe per cycle; any write that does not
// continue a started pair returns the detector to idle.
module kwdt_keyseq
    import kwdt_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_byte,
    input  logic        wr_word,
    input  logic [3:0]  addr,
    input  logic [15:0] key,
    output logic        refresh_hit,
    output logic        unlock_hit
);

    key_state_e state_q;
    key_state_e state_d;
    logic       any_wr;
    logic       cmd_wr;

    // Classify the current write.
    always_comb begin
        any_wr = wr_byte | wr_word;
        cmd_wr = wr_word && (addr == ADR_COUNT);
    end

    // Completion pulses for the two key pairs.
    always_comb begin
        refresh_hit = cmd_wr && (state_q == KS_HAVE_REFRESH) && (key == KEY_REFRESH_B);
        unlock_hit  = cmd_wr && (state_q == KS_HAVE_UNLOCK)  && (key == KEY_UNLOCK_B);
    end

    // Next-state selection: only a first key word from idle arms the detector.
    always_comb begin
        state_d = state_q;
        if (any_wr) begin
            if (cmd_wr && state_q == KS_IDLE && key == KEY_REFRESH_A) begin
                state_d = KS_HAVE_REFRESH;
            end else if (cmd_wr && state_q == KS_IDLE && key == KEY_UNLOCK_A) begin
                state_d = KS_HAVE_UNLOCK;
            end else begin
                state_d = KS_IDLE;
            end
        end
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= KS_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

endmodule

// File: rtl/kwdt_cfg.sv
// Configuration registers with an unlock span and a permanent freeze.
// Holds run/allow bits, clock select, terminal count and window. Writes
// land only while the unlock span counter is nonzero; the flag-clear
// request is passed through ungated.
module kwdt_cfg
    import kwdt_pkg::*;
#(
    parameter int              DATA_W    = 32,
    parameter logic [DATA_W-1:0] TERM_RST = 32'h0000_1500,
    parameter int              OPEN_SPAN = 128
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_byte,
    input  logic              wr_word,
    input  logic [3:0]        addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              unlock_hit,
    output logic              run_q,
    output logic              allow_q,
    output logic [1:0]        sel_q,
    output logic [DATA_W-1:0] term_q,
    output logic [DATA_W-1:0] win_q,
    output logic              cfg_open,
    output logic              frozen,
    output logic              flag_clr
);

    localparam int SPAN_W = $clog2(OPEN_SPAN + 1);
    localparam logic [SPAN_W-1:0] SPAN_LOAD = SPAN_W'(OPEN_SPAN);

    logic [SPAN_W-1:0] span_q;
    logic ctrl_ok, stat_ok, term_ok, win_ok, freeze_wr;

    // Decode accepted writes.
    always_comb begin
        cfg_open  = (span_q != '0);
        frozen    = run_q & ~allow_q;
        ctrl_ok   = wr_byte && (addr == ADR_CTRL) && cfg_open;
        stat_ok   = wr_byte && (addr == ADR_STAT) && cfg_open;
        term_ok   = wr_word && (addr == ADR_TERM) && cfg_open;
        win_ok    = wr_word && (addr == ADR_WIN)  && cfg_open;
        freeze_wr = ctrl_ok && wdata[CTRL_RUN_BIT] && !wdata[CTRL_ALLOW_BIT];
        flag_clr  = wr_byte && (addr == ADR_STAT) && wdata[STAT_FLAG_BIT];
    end

    // Unlock span: load on unlock, close on freeze, count down otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            span_q <= '0;
        end else if (unlock_hit && !frozen) begin
            span_q <= SPAN_LOAD;
        end else if (freeze_wr) begin
            span_q <= '0;
        end else if (span_q != '0) begin
            span_q <= span_q - 1'b1;
        end
    end

    // Control byte fields.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q   <= 1'b0;
            allow_q <= 1'b1;
        end else if (ctrl_ok) begin
            run_q   <= wdata[CTRL_RUN_BIT];
            allow_q <= wdata[CTRL_ALLOW_BIT];
        end
    end

    // Clock select field of the status byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_q <= 2'd0;
        end else if (stat_ok) begin
            sel_q <= wdata[1:0];
        end
    end

    // Terminal count and window words.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            term_q <= TERM_RST;
            win_q  <= '0;
        end else begin
            if (term_ok) term_q <= wdata;
            if (win_ok)  win_q  <= wdata;
        end
    end

endmodule

// File: rtl/kwdt_core.sv
// Counting core: tick selection, live count, timeout and window checks,
// sticky flag and the fixed-length reset pulse.
// Assumes tick inputs are single-cycle pulses in the bus clock domain.
module kwdt_core
    import kwdt_pkg::*;
#(
    parameter int CNT_W     = 32,
    parameter int PULSE_LEN = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [1:0]       sel,
    input  logic             tick_slow,
    input  logic             tick_32k,
    input  logic             tick_ext,
    input  logic [CNT_W-1:0] term,
    input  logic [CNT_W-1:0] win,
    input  logic             refresh_hit,
    input  logic             flag_clr,
    output logic [CNT_W-1:0] cnt_q,
    output logic             flag_q,
    output logic             rst_req,
    output logic             tmo_hit,
    output logic             bad_refresh
);

    localparam int PW = $clog2(PULSE_LEN + 1);
    localparam logic [PW-1:0] PULSE_LOAD = PW'(PULSE_LEN);

    logic          tick;
    logic          good_refresh;
    logic [PW-1:0] pulse_q;

    // Pick the active tick source.
    always_comb begin
        case (tick_sel_e'(sel))
            TICK_BUS:  tick = 1'b1;
            TICK_SLOW: tick = tick_slow;
            TICK_32K:  tick = tick_32k;
            default:   tick = tick_ext;
        endcase
    end

    // Timeout and refresh qualification.
    always_comb begin
        tmo_hit      = run && (cnt_q == term);
        bad_refresh  = refresh_hit && (win != '0) && (cnt_q < win);
        good_refresh = refresh_hit && !bad_refresh;
    end

    // Live counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (good_refresh || tmo_hit) begin
            cnt_q <= '0;
        end else if (run && tick) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // Sticky timeout flag, cleared by writing one.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag_q <= 1'b0;
        end else if (tmo_hit) begin
            flag_q <= 1'b1;
        end else if (flag_clr) begin
            flag_q <= 1'b0;
        end
    end

    // Reset pulse stretcher.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pulse_q <= '0;
        end else if (tmo_hit || bad_refresh) begin
            pulse_q <= PULSE_LOAD;
        end else if (pulse_q != '0) begin
            pulse_q <= pulse_q - 1'b1;
        end
    end

    // Reset output follows the stretcher.
    always_comb rst_req = (pulse_q != '0);

endmodule

// File: rtl/kwdt_top.sv
// Keyed-refresh watchdog top: joins the key detector, the configuration
// registers and the counting core, and forms the read data.
// Assumes one bus access per cycle and a combinational read path.
module kwdt_top #(
    parameter int                  CNT_W     = 32,
    parameter logic [CNT_W-1:0]    TERM_RST  = 32'h0000_1500,
    parameter int                  OPEN_SPAN = 128,
    parameter int                  PULSE_LEN = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_lp_i,
    input  logic             tick_32k_i,
    input  logic             tick_ext_i,
    input  logic [3:0]       bus_addr_i,
    input  logic [CNT_W-1:0] bus_wdata_i,
    input  logic             bus_wr_byte_i,
    input  logic             bus_wr_word_i,
    output logic [CNT_W-1:0] bus_rdata_o,
    output logic             wdog_rst_o
);

    logic             refresh_hit, unlock_hit;
    logic             run_q, allow_q, cfg_open, frozen, flag_clr;
    logic [1:0]       sel_q;
    logic [CNT_W-1:0] term_q, win_q, cnt_q;
    logic             flag_q, tmo_hit, bad_refresh;
    logic [7:0]       ctrl_byte, stat_byte;

    kwdt_keyseq u_keys (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_byte     (bus_wr_byte_i),
        .wr_word     (bus_wr_word_i),
        .addr        (bus_addr_i),
        .key         (bus_wdata_i[15:0]),
        .refresh_hit (refresh_hit),
        .unlock_hit  (unlock_hit)
    );

    kwdt_cfg #(
        .DATA_W    (CNT_W),
        .TERM_RST  (TERM_RST),
        .OPEN_SPAN (OPEN_SPAN)
    ) u_cfg (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_byte    (bus_wr_byte_i),
        .wr_word    (bus_wr_word_i),
        .addr       (bus_addr_i),
        .wdata      (bus_wdata_i),
        .unlock_hit (unlock_hit),
        .run_q      (run_q),
        .allow_q    (allow_q),
        .sel_q      (sel_q),
        .term_q     (term_q),
        .win_q      (win_q),
        .cfg_open   (cfg_open),
        .frozen     (frozen),
        .flag_clr   (flag_clr)
    );

    kwdt_core #(
        .CNT_W     (CNT_W),
        .PULSE_LEN (PULSE_LEN)
    ) u_core (
        .clk         (clk),
        .rst_n       (rst_n),
        .run         (run_q),
        .sel         (sel_q),
        .tick_slow   (tick_lp_i),
        .tick_32k    (tick_32k_i),
        .tick_ext    (tick_ext_i),
        .term        (term_q),
        .win         (win_q),
        .refresh_hit (refresh_hit),
        .flag_clr    (flag_clr),
        .cnt_q       (cnt_q),
        .flag_q      (flag_q),
        .rst_req     (wdog_rst_o),
        .tmo_hit     (tmo_hit),
        .bad_refresh (bad_refresh)
    );

    // Pack the two control bytes.
    always_comb begin
        ctrl_byte = {run_q, 1'b0, allow_q, 5'b0};
        stat_byte = {1'b0, flag_q, 4'b0, sel_q};
    end

    // Read multiplexer on word address.
    always_comb begin
        case (bus_addr_i[3:2])
            2'd0:    bus_rdata_o = {{(CNT_W-16){1'b0}}, stat_byte, ctrl_byte};
            2'd1:    bus_rdata_o = cnt_q;
            2'd2:    bus_rdata_o = term_q;
            default: bus_rdata_o = win_q;
        endcase
    end

endmodule

// File: rtl/kwdt_chk.sv
// Property checker for the keyed-refresh watchdog, bound into kwdt_top.
// Observes ports and the hand-off signals between the internal blocks.
module kwdt_chk #(
    parameter int CNT_W     = 32,
    parameter int PULSE_LEN = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic [3:0]       bus_addr_i,
    input logic [CNT_W-1:0] bus_wdata_i,
    input logic             bus_wr_byte_i,
    input logic             wdog_rst_o,
    input logic             refresh_hit,
    input logic             bad_refresh,
    input logic             tmo_hit,
    input logic             cfg_open,
    input logic             frozen,
    input logic             flag_q,
    input logic [CNT_W-1:0] cnt_q,
    input logic [CNT_W-1:0] term_q
);

    localparam int HW = $clog2(PULSE_LEN + 1) + 1;
    logic [HW-1:0] high_run;

    // Cycles the reset output has been high since the last trigger.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            high_run <= '0;
        end else if (tmo_hit || bad_refresh) begin
            high_run <= '0;
        end else if (wdog_rst_o) begin
            high_run <= high_run + 1'b1;
        end
    end

    // R2
    refresh_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (refresh_hit && !bad_refresh) |=> (cnt_q == '0));

    // R4
    term_guarded_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(term_q) |-> $past(cfg_open));

    // R6
    frozen_closed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frozen |-> !cfg_open);

    // R7
    flag_clear_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(flag_q) |-> $past(bus_wr_byte_i && bus_addr_i == 4'd1 && bus_wdata_i[6]));

    // R9
    rst_rise_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wdog_rst_o) |-> $past(tmo_hit || bad_refresh));

    // R9
    rst_pulse_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(wdog_rst_o) |-> (high_run == HW'(PULSE_LEN)));

    // R11
    count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(cnt_q) |-> (cnt_q == '0 || cnt_q == CNT_W'($past(cnt_q) + 1'b1)));

endmodule

bind kwdt_top kwdt_chk #(
    .CNT_W     (CNT_W),
    .PULSE_LEN (PULSE_LEN)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .bus_addr_i    (bus_addr_i),
    .bus_wdata_i   (bus_wdata_i),
    .bus_wr_byte_i (bus_wr_byte_i),
    .wdog_rst_o    (wdog_rst_o),
    .refresh_hit   (refresh_hit),
    .bad_refresh   (bad_refresh),
    .tmo_hit       (tmo_hit),
    .cfg_open      (cfg_open),
    .frozen        (frozen),
    .flag_q        (flag_q),
    .cnt_q         (cnt_q),
    .term_q        (term_q)
);

// File: tb/kwdt_top_tb.sv
`timescale 1ns/1ps
// Directed bench for kwdt_top: one task per scenario, inputs driven on
// falling edges, results read just after falling edges.
module kwdt_top_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_lp = 1'b0, tick_32k = 1'b0, tick_ext = 1'b0;
    logic [3:0]  bus_addr = 4'd0;
    logic [31:0] bus_wdata = 32'd0;
    logic        bus_wr_byte = 1'b0, bus_wr_word = 1'b0;
    logic [31:0] bus_rdata;
    logic        wdog_rst;

    int n_checks = 0;
    int n_fails  = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    kwdt_top u_dut (
        .clk           (clk),
        .rst_n         (rst_n),
        .tick_lp_i     (tick_lp),
        .tick_32k_i    (tick_32k),
        .tick_ext_i    (tick_ext),
        .bus_addr_i    (bus_addr),
        .bus_wdata_i   (bus_wdata),
        .bus_wr_byte_i (bus_wr_byte),
        .bus_wr_word_i (bus_wr_word),
        .bus_rdata_o   (bus_rdata),
        .wdog_rst_o    (wdog_rst)
    );

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    task automatic wr_word(input logic [3:0] a, input logic [31:0] d);
        bus_addr = a; bus_wdata = d; bus_wr_word = 1'b1;
        @(negedge clk);
        bus_wr_word = 1'b0;
    endtask

    task automatic wr_byte(input logic [3:0] a, input logic [7:0] d);
        bus_addr = a; bus_wdata = {24'd0, d}; bus_wr_byte = 1'b1;
        @(negedge clk);
        bus_wr_byte = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse(input int which);
        case (which)
            1: tick_lp = 1'b1;
            2: tick_32k = 1'b1;
            default: tick_ext = 1'b1;
        endcase
        @(negedge clk);
        tick_lp = 1'b0; tick_32k = 1'b0; tick_ext = 1'b0;
    endtask

    task automatic unlock();
        wr_word(4'd4, 32'h0000_C520);
        wr_word(4'd4, 32'h0000_D928);
    endtask

    task automatic refresh();
        wr_word(4'd4, 32'h0000_A602);
        wr_word(4'd4, 32'h0000_B480);
    endtask

    // Leaves the count at 0 with the given settings applied on the last edge.
    task automatic setup(input logic [31:0] term, input logic [31:0] win,
                         input logic [7:0] sel, input logic [7:0] ctrl);
        unlock();
        wr_byte(4'd0, 8'h20);
        wr_word(4'd12, 32'd0);
        refresh();
        wr_word(4'd8, term);
        wr_word(4'd12, win);
        wr_byte(4'd1, sel);
        wr_byte(4'd0, ctrl);
    endtask

    task automatic t_reset();
        logic [31:0] v;
        rd(4'd0, v);  check("R1", "control/status", v, 32'h0000_0020);
        rd(4'd4, v);  check("R1", "count", v, 32'd0);
        rd(4'd8, v);  check("R1", "terminal", v, 32'h0000_1500);
        rd(4'd12, v); check("R1", "window", v, 32'd0);
        check("R1", "reset out", {31'd0, wdog_rst}, 32'd0);
    endtask

    task automatic t_lock();
        logic [31:0] v;
        wr_word(4'd8, 32'd50);
        rd(4'd8, v); check("R4", "terminal write while locked", v, 32'h0000_1500);
        wr_byte(4'd0, 8'hA0);
        rd(4'd0, v); check("R4", "control write while locked", v, 32'h0000_0020);
        unlock();
        wr_word(4'd8, 32'd50);
        rd(4'd8, v); check("R4", "terminal write after unlock", v, 32'd50);
    endtask

    task automatic t_span();
        logic [31:0] v;
        unlock();
        idle(127);
        wr_word(4'd8, 32'd77);
        rd(4'd8, v); check("R5", "write on edge 128", v, 32'd77);
        wr_word(4'd8, 32'd99);
        rd(4'd8, v); check("R5", "write on edge 129", v, 32'd77);
    endtask

    task automatic t_refresh();
        logic [31:0] v;
        setup(32'd1000, 32'd0, 8'h00, 8'hA0);
        idle(30);
        rd(4'd4, v); check("R11", "live count after 30 clocks", v, 32'd30);
        refresh();
        rd(4'd4, v); check("R2", "count after refresh", v, 32'd0);
        idle(7);
        rd(4'd4, v); check("R8", "bus-clock tick count", v, 32'd7);
    endtask

    task automatic t_abort();
        logic [31:0] v;
        setup(32'd1000, 32'd0, 8'h00, 8'hA0);
        idle(10);
        wr_word(4'd4, 32'h0000_A602);
        wr_word(4'd4, 32'h0000_1111);
        wr_word(4'd4, 32'h0000_B480);
        rd(4'd4, v); check("R3", "wrong second word", v, 32'd13);
        wr_word(4'd4, 32'h0000_A602);
        wr_byte(4'd1, 8'h00);
        wr_word(4'd4, 32'h0000_B480);
        rd(4'd4, v); check("R3", "write between keys", v, 32'd16);
        wr_word(4'd4, 32'h0000_B480);
        rd(4'd4, v); check("R3", "lone second word", v, 32'd17);
    endtask

    task automatic t_ticks();
        logic [31:0] v;
        setup(32'd1000, 32'd0, 8'h01, 8'hA0);
        pulse(1); pulse(1); pulse(2); pulse(1); pulse(3);
        idle(3);
        rd(4'd4, v); check("R8", "slow tick select", v, 32'd3);
        setup(32'd1000, 32'd0, 8'h02, 8'hA0);
        pulse(2); pulse(1); pulse(2); pulse(3);
        rd(4'd4, v); check("R8", "32k tick select", v, 32'd2);
        setup(32'd1000, 32'd0, 8'h03, 8'hA0);
        pulse(3); pulse(3); pulse(1); pulse(3); pulse(2); pulse(3);
        rd(4'd4, v); check("R8", "external tick select", v, 32'd4);
        setup(32'd1000, 32'd0, 8'h00, 8'h20);
        idle(5);
        rd(4'd4, v); check("R8", "count held while disabled", v, 32'd0);
    endtask

    task automatic t_timeout();
        logic [31:0] v;
        int highs;
        setup(32'd20, 32'd0, 8'h00, 8'hA0);
        idle(20);
        rd(4'd4, v); check("R9", "count at terminal", v, 32'd20);
        check("R9", "reset before timeout", {31'd0, wdog_rst}, 32'd0);
        idle(1);
        check("R9", "reset on timeout", {31'd0, wdog_rst}, 32'd1);
        rd(4'd4, v); check("R9", "count cleared on timeout", v, 32'd0);
        rd(4'd0, v); check("R9", "flag set", {31'd0, v[14]}, 32'd1);
        highs = 1;
        for (int i = 0; i < 15; i++) begin
            @(negedge clk);
            if (wdog_rst) highs++;
        end
        check("R9", "high samples", highs, 32'd16);
        idle(1);
        check("R9", "reset released", {31'd0, wdog_rst}, 32'd0);
        unlock();
        wr_byte(4'd0, 8'h20);
    endtask

    task automatic t_flag();
        logic [31:0] v;
        idle(130);
        wr_byte(4'd1, 8'h03);
        rd(4'd0, v); check("R7", "write 0 to flag, locked select", v[15:8], 32'h40);
        wr_byte(4'd1, 8'h40);
        rd(4'd0, v); check("R7", "write 1 clears flag while locked", v[15:8], 32'h00);
    endtask

    task automatic t_window();
        logic [31:0] v;
        setup(32'd1000, 32'd10, 8'h00, 8'hA0);
        idle(4);
        refresh();
        check("R10", "early refresh fires reset", {31'd0, wdog_rst}, 32'd1);
        rd(4'd4, v); check("R10", "early refresh keeps count", v, 32'd6);
        rd(4'd0, v); check("R10", "early refresh leaves flag", {31'd0, v[14]}, 32'd0);
        idle(20);
        refresh();
        rd(4'd4, v); check("R10", "late refresh accepted", v, 32'd0);
        check("R10", "no reset on late refresh", {31'd0, wdog_rst}, 32'd0);
    endtask

    task automatic t_freeze();
        logic [31:0] v;
        setup(32'd1000, 32'd0, 8'h00, 8'h80);
        unlock();
        wr_word(4'd8, 32'd55);
        rd(4'd8, v); check("R6", "terminal frozen", v, 32'd1000);
        wr_byte(4'd0, 8'h20);
        rd(4'd0, v); check("R6", "control frozen", v[7:0], 32'h80);
    endtask

    initial begin
        idle(3);
        rst_n = 1'b1;
        t_reset();
        t_lock();
        t_span();
        t_refresh();
        t_abort();
        t_ticks();
        t_timeout();
        t_flag();
        t_window();
        t_freeze();
        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog (all requirements): actual hung run expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
            $finish;
        end
    end

endmodule